// File: doc/BRIEF.md
# Call Barring First-Key Gate

This block sits between a debounced keypad and the dialing engine of a telephone line interface. It decides, from the first key pressed after the line goes off-hook, whether the call may proceed. When the first key is a barred digit, the gate shuts the keypad path for the rest of the call. Nothing reaches the dialer until the handset has been put back on-hook for a full debounce interval.

Time is counted in ticks of a 1 ms strobe. A 2-bit lock selector sets which digits are barred. It also sets how long the hook level must stay steady before a change is accepted. While barring is active, every newly confirmed off-hook opens a hold-off window. During that window the dial pulse line is held low and key presses are discarded. With barring switched off, the gate passes every key as soon as off-hook is confirmed.

Top module: `call_bar_gate`

## Requirements
- R1: `lock_sel` 2'b00 bars nothing, 2'b01 bars only key code 0, and 2'b10 or 2'b11 bar key codes 0 and 9. Key codes 0 to 9 are the digits; all other codes are non-digit keys and are never barred.
- R2: If the first key accepted in the armed state (`gate_state` 2) is barred, that key and every later key are withheld from `key_fwd_vld`, and `gate_state` becomes 4 (barred).
- R3: The barred state persists through any hook activity shorter than the debounce time. Only a confirmed on-hook, or `rst_n`, clears it, after which `gate_state` is 0.
- R4: With barring enabled, a confirmed off-hook enters `gate_state` 1 for `DELAY_MS` ticks (default 300). `dp_hold_low` is high exactly during that state. The gate then moves to `gate_state` 2.
- R5: Keys pressed while `gate_state` is 1 are never forwarded and do not count as the first key.
- R6: A non-barred first key is forwarded, and `gate_state` becomes 3 (open). In the open state every key is forwarded, including 0 and 9. A forwarded key appears on `key_fwd_vld`/`key_fwd_code` one clock after `key_vld`, carrying the same code.
- R7: With `lock_sel` 2'b00, a confirmed off-hook goes straight to `gate_state` 3, with no hold-off and `dp_hold_low` staying low.
- R8: A hook level change is confirmed only after it has held for `DB_LOCK_MS` ticks (default 20) when barring is enabled, or `DB_FREE_MS` ticks (default 150) when it is disabled. Shorter excursions change nothing.
- R9: After reset, and while on-hook, `gate_state` is 0, `dp_hold_low` is low and keys are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| onhook_raw | input | 1 | Raw hook switch level, 1 = on-hook |
| lock_sel | input | 2 | Barring selector (see R1) |
| key_vld | input | 1 | Debounced key strobe |
| key_code | input | KEY_W | Code of the pressed key |
| key_fwd_vld | output | 1 | Key strobe passed to the dialer |
| key_fwd_code | output | KEY_W | Code passed to the dialer |
| dp_hold_low | output | 1 | Request to force the dial pulse line low |
| gate_state | output | 3 | 0 on-hook, 1 hold-off, 2 armed, 3 open, 4 barred |

## Verification
The internal state is visible at the ports. A latch that fails to stick shows up as a forwarded strobe on the very next key after a barred first digit. A first-key check that runs twice shows up as a dropped 0 or 9 after a valid first key. A wrong debounce limit moves the `gate_state` change by tens of ticks. A glitch that is wrongly accepted drops the gate to state 0 and wipes the barred latch, so the next off-hook forwards keys it should not. A hold-off counter that is off by one shifts the fall of `dp_hold_low` by a millisecond, and a key pressed in that window would leak through.

// File: rtl/call_bar_pkg.sv
package call_bar_pkg;

   typedef enum logic [2:0] {
      ST_ONHOOK = 3'd0,
      ST_DELAY  = 3'd1,
      ST_ARMED  = 3'd2,
      ST_OPEN   = 3'd3,
      ST_BARRED = 3'd4
   } gate_st_e;

   localparam logic [1:0] LK_NONE = 2'b00;
   localparam logic [1:0] LK_ZERO = 2'b01;

endpackage

// File: rtl/hook_filter.sv
module hook_filter #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          raw_onhook,
   input  logic [CW-1:0] limit,
   output logic          onhook
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         onhook <= 1'b1;
         cnt_q  <= '0;
      end else if (raw_onhook == onhook) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q >= limit - 1'b1) begin
            onhook <= raw_onhook;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R8
   flip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (onhook != $past(onhook)) |-> ($past(tick) && ($past(raw_onhook) != $past(onhook))));

endmodule

// File: rtl/span_timer.sv
module span_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (tick && (cnt_q != limit))
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == limit);

   // R4
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= limit));

   // R4
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr && $stable(limit)) |=> done);

endmodule

// File: rtl/first_key_judge.sv
module first_key_judge #(
   parameter int KEY_W = 4
) (
   input  logic [KEY_W-1:0] code,
   input  logic [1:0]       lock,
   output logic             barred
);

   logic is_zero, is_nine;

   assign is_zero = (code == KEY_W'(0));
   assign is_nine = (code == KEY_W'(9));

   // R1: zero-only mode bars 0, both upper codes bar 0 and 9
   always_comb begin
      unique case (lock)
         2'b00:   barred = 1'b0;
         2'b01:   barred = is_zero;
         default: barred = is_zero | is_nine;
      endcase
   end

endmodule

// File: rtl/call_bar_gate.sv
module call_bar_gate
   import call_bar_pkg::*;
#(
   parameter int KEY_W      = 4,
   parameter int DELAY_MS   = 300,
   parameter int DB_LOCK_MS = 20,
   parameter int DB_FREE_MS = 150,
   parameter int KEY_REG    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1ms,
   input  logic             onhook_raw,
   input  logic [1:0]       lock_sel,
   input  logic             key_vld,
   input  logic [KEY_W-1:0] key_code,
   output logic             key_fwd_vld,
   output logic [KEY_W-1:0] key_fwd_code,
   output logic             dp_hold_low,
   output logic [2:0]       gate_state
);

   localparam int DB_MAX = (DB_LOCK_MS > DB_FREE_MS) ? DB_LOCK_MS : DB_FREE_MS;
   localparam int MS_MAX = (DB_MAX > DELAY_MS) ? DB_MAX : DELAY_MS;
   localparam int CW     = $clog2(MS_MAX + 1);

   generate
      if (KEY_W < 4) begin : g_bad_key
         $error("KEY_W must hold codes 0 to 9");
      end
      if (DELAY_MS < 1 || DB_LOCK_MS < 1 || DB_FREE_MS < 1) begin : g_bad_time
         $error("all time limits must be at least one tick");
      end
      if (KEY_REG != 0 && KEY_REG != 1) begin : g_bad_reg
         $error("KEY_REG selects 0 or 1");
      end
   endgenerate

   gate_st_e      st_q, st_d;
   logic          lock_on;
   logic          hook_on;
   logic          dly_done;
   logic          barred;
   logic          pass;
   logic [CW-1:0] db_limit;

   assign lock_on  = (lock_sel != LK_NONE);
   assign db_limit = lock_on ? CW'(DB_LOCK_MS) : CW'(DB_FREE_MS);

   hook_filter #(.CW(CW)) u_hook (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_1ms),
      .raw_onhook (onhook_raw),
      .limit      (db_limit),
      .onhook     (hook_on)
   );

   span_timer #(.CW(CW)) u_holdoff (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q != ST_DELAY),
      .tick  (tick_1ms),
      .limit (CW'(DELAY_MS)),
      .done  (dly_done)
   );

   first_key_judge #(.KEY_W(KEY_W)) u_judge (
      .code   (key_code),
      .lock   (lock_sel),
      .barred (barred)
   );

   always_comb begin
      st_d = st_q;
      if (hook_on) begin
         st_d = ST_ONHOOK;
      end else begin
         unique case (st_q)
            ST_ONHOOK: st_d = lock_on ? ST_DELAY : ST_OPEN;
            ST_DELAY:  if (dly_done) st_d = ST_ARMED;
            ST_ARMED:  if (key_vld) st_d = barred ? ST_BARRED : ST_OPEN;
            default:   st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_ONHOOK;
      else        st_q <= st_d;
   end

   assign pass = key_vld && ((st_q == ST_OPEN) || ((st_q == ST_ARMED) && !barred));

   assign dp_hold_low = (st_q == ST_DELAY);
   assign gate_state  = st_q;

   generate
      if (KEY_REG == 1) begin : g_fwd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               key_fwd_vld  <= 1'b0;
               key_fwd_code <= '0;
            end else begin
               key_fwd_vld  <= pass;
               key_fwd_code <= pass ? key_code : key_fwd_code;
            end
         end

         // R2
         barred_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_BARRED) |-> !key_fwd_vld);

         // R5
         holdoff_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_DELAY) |=> !key_fwd_vld);
      end else begin : g_fwd_comb
         assign key_fwd_vld  = pass;
         assign key_fwd_code = key_code;
      end
   endgenerate

   // R3
   barred_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BARRED && !hook_on) |=> (st_q == ST_BARRED));

   // R4
   holdoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dp_hold_low) |-> ($past(st_q) == ST_ONHOOK && $past(lock_sel) != LK_NONE));

   // R7
   free_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ONHOOK && !hook_on && lock_sel == LK_NONE) |=> (st_q == ST_OPEN));

endmodule

// File: tb/call_bar_gate_test.sv
module call_bar_gate_test;

   localparam int DLY = 300;
   localparam int DBL = 20;
   localparam int DBF = 150;
   // {lock[1:0], first[3:0], second[3:0], exp_first, exp_second}
   localparam int NV = 8;
   localparam logic [11:0] VEC [NV] = '{
      {2'd2, 4'd0,  4'd5, 1'b0, 1'b0},
      {2'd2, 4'd9,  4'd3, 1'b0, 1'b0},
      {2'd2, 4'd4,  4'd9, 1'b1, 1'b1},
      {2'd1, 4'd9,  4'd0, 1'b1, 1'b1},
      {2'd1, 4'd0,  4'd7, 1'b0, 1'b0},
      {2'd3, 4'd9,  4'd2, 1'b0, 1'b0},
      {2'd0, 4'd0,  4'd9, 1'b1, 1'b1},
      {2'd1, 4'd11, 4'd0, 1'b1, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       onhook_raw = 1'b1;
   logic [1:0] lock_sel = 2'b00;
   logic       key_vld = 1'b0;
   logic [3:0] key_code = '0;
   logic       key_fwd_vld;
   logic [3:0] key_fwd_code;
   logic       dp_hold_low;
   logic [2:0] gate_state;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   call_bar_gate uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_1ms     (tick),
      .onhook_raw   (onhook_raw),
      .lock_sel     (lock_sel),
      .key_vld      (key_vld),
      .key_code     (key_code),
      .key_fwd_vld  (key_fwd_vld),
      .key_fwd_code (key_fwd_code),
      .dp_hold_low  (dp_hold_low),
      .gate_state   (gate_state)
   );

   always #2.5 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         tick = ~tick;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (2 * n) @(negedge clk);
   endtask

   task automatic press(input logic [3:0] code);
      @(negedge clk);
      key_vld  = 1'b1;
      key_code = code;
      @(negedge clk);
      key_vld  = 1'b0;
   endtask

   function automatic int db_of(input logic [1:0] lk);
      return (lk == 2'b00) ? DBF : DBL;
   endfunction

   task automatic go_offhook(input logic [1:0] lk);
      lock_sel   = lk;
      onhook_raw = 1'b0;
      wait_ticks(db_of(lk) + 3);
      if (lk != 2'b00) begin
         chk("R4 holdoff state", gate_state, 1);
         chk("R4 dp low request", dp_hold_low, 1);
         wait_ticks(DLY);
         chk("R4 armed after holdoff", gate_state, 2);
         chk("R4 dp released", dp_hold_low, 0);
      end else begin
         chk("R7 open at once", gate_state, 3);
         chk("R7 no dp request", dp_hold_low, 0);
      end
   endtask

   task automatic go_onhook();
      onhook_raw = 1'b1;
      wait_ticks(db_of(lock_sel) + 3);
      chk("R3 back on-hook", gate_state, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 reset state", gate_state, 0);
      chk("R9 reset fwd", key_fwd_vld, 0);
      chk("R9 reset dp", dp_hold_low, 0);
      press(4'd5);
      chk("R9 key on-hook dropped", key_fwd_vld, 0);

      // R1 R2 R6 vector walk
      for (int i = 0; i < NV; i++) begin
         logic [11:0] v;
         v = VEC[i];
         go_offhook(v[11:10]);
         press(v[9:6]);
         chk("R1 first key fwd", key_fwd_vld, v[1]);
         if (v[1]) chk("R6 first key code", key_fwd_code, v[9:6]);
         press(v[5:2]);
         chk("R2 R6 second key fwd", key_fwd_vld, v[0]);
         if (v[0]) chk("R6 second key code", key_fwd_code, v[5:2]);
         chk("R2 R6 state", gate_state, v[1] ? 3 : 4);
         go_onhook();
      end

      // R5 keys in holdoff ignored and not counted
      lock_sel   = 2'b10;
      onhook_raw = 1'b0;
      wait_ticks(DBL + 3);
      chk("R5 in holdoff", gate_state, 1);
      press(4'd0);
      chk("R5 holdoff key dropped", key_fwd_vld, 0);
      chk("R5 still holdoff", gate_state, 1);
      wait_ticks(DLY);
      chk("R5 armed after holdoff", gate_state, 2);
      press(4'd6);
      chk("R5 first key after holdoff", key_fwd_vld, 1);
      go_onhook();

      // R3 R8 barred latch survives short on-hook glitch
      go_offhook(2'b10);
      press(4'd9);
      chk("R2 barred", gate_state, 4);
      onhook_raw = 1'b1;
      wait_ticks(DBL - 3);
      onhook_raw = 1'b0;
      wait_ticks(DBL + 5);
      chk("R3 glitch keeps barred", gate_state, 4);
      press(4'd3);
      chk("R3 still muted", key_fwd_vld, 0);
      go_onhook();
      go_offhook(2'b10);
      press(4'd5);
      chk("R3 latch cleared", key_fwd_vld, 1);
      go_onhook();

      // R8 long debounce when barring disabled
      go_offhook(2'b00);
      onhook_raw = 1'b1;
      wait_ticks(100);
      onhook_raw = 1'b0;
      wait_ticks(10);
      chk("R8 free glitch ignored", gate_state, 3);
      press(4'd9);
      chk("R8 open after glitch", key_fwd_vld, 1);
      go_onhook();

      // R8 short off-hook excursion ignored
      lock_sel   = 2'b10;
      onhook_raw = 1'b0;
      wait_ticks(DBL - 3);
      onhook_raw = 1'b1;
      wait_ticks(DBL + 5);
      chk("R8 short offhook ignored", gate_state, 0);
      chk("R8 no dp request", dp_hold_low, 0);

      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule